// File: doc/BRIEF.md
# Lane-Parallel Vector Compare and Predicate Unit

This unit compares two 128-bit vector operands as packed lanes of 8, 16 or 32 bits. The lane size is chosen for each operation. Every lane gets three tests in the same cycle: equal, less-than as signed, and less-than as unsigned. Each test yields a 16-bit predicate mask with one bit per byte position. In a wider lane, the lane's result is copied into every byte bit it covers, so units downstream can gate their byte enables directly from the mask.

The same unit also moves data between a scalar register and a vector lane. An insert operation writes the low bits of a 32-bit scalar into a chosen lane of the first operand. An extract operation returns a chosen lane as a zero-extended 32-bit scalar. The unit has one register stage, so results appear one clock after an accepted request. Predicates are therefore ready alongside a vector arithmetic operation issued in the same cycle, and no stall is added.

Top module: `vcmp_pred_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and low otherwise (one-clock latency).
- R2: For op code 0 (compare) with width code 0 (8-bit lanes), bit i of `out_eq` is 1 exactly when bits [8i+7:8i] of `in_a` and `in_b` are equal.
- R3: For a compare, bit i of `out_lts` is 1 exactly when the lane holding byte i of `in_a` is less than that lane of `in_b` as two's-complement numbers.
- R4: For a compare, bit i of `out_ltu` is 1 exactly when the lane holding byte i of `in_a` is less than that lane of `in_b` as unsigned numbers.
- R5: Width code 1 selects 16-bit lanes and code 2 selects 32-bit lanes. Lane k covers bits [k*W+W-1:k*W], and its three results are copied into all of its byte bits in each mask.
- R6: Width code 3 is invalid. It gives all-zero masks, `out_vec` and `out_scalar`, and sets `out_err` to 1. `out_err` is 0 for codes 0 to 2.
- R7: Op code 1 (insert) gives `out_vec` equal to `in_a` with lane `in_lane` (2-bit index, lane width from the width code) replaced by the low W bits of `in_scalar`. Masks and `out_scalar` are zero.
- R8: Op code 2 (extract) gives `out_scalar` equal to lane `in_lane` of `in_a`, zero-extended to 32 bits. Masks and `out_vec` are zero.
- R9: For a compare, `out_vec` and `out_scalar` are zero.
- R10: Op code 3 (idle op) gives zero masks, `out_vec` and `out_scalar`. `out_err` still follows R6.
- R11: While `in_valid` is low, all result outputs keep their values.
- R12: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request accepted this cycle |
| in_op | input | 2 | 0 compare, 1 insert, 2 extract, 3 idle |
| in_width | input | 2 | 0 8-bit, 1 16-bit, 2 32-bit, 3 invalid |
| in_a | input | 128 | First vector operand |
| in_b | input | 128 | Second vector operand |
| in_scalar | input | 32 | Scalar source for insert |
| in_lane | input | 2 | Lane index for insert/extract |
| out_valid | output | 1 | Result valid |
| out_eq | output | 16 | Equal predicate mask, one bit per byte |
| out_lts | output | 16 | Signed less-than mask |
| out_ltu | output | 16 | Unsigned less-than mask |
| out_vec | output | 128 | Insert result vector |
| out_scalar | output | 32 | Extract result |
| out_err | output | 1 | Invalid lane width code |

## Verification
A wrong lane-width selection or a wrong lane boundary shows in the very next valid cycle. Mask bits then disagree with their byte neighbours or with the signed ordering, and this is exposed most sharply by operands that differ only in their sign bits. A corrupted result register either fails to hold during idle cycles or leaks data into fields that must be zero for the current op, and both are visible one clock after the request. The bench sweeps every op, every width code and every lane index over operands that are random, equal, sparsely altered and sign-flipped.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  typedef enum logic [1:0] {
    LW_8   = 2'd0,
    LW_16  = 2'd1,
    LW_32  = 2'd2,
    LW_BAD = 2'd3
  } lane_w_e;

  typedef enum logic [1:0] {
    OP_CMP  = 2'd0,
    OP_INS  = 2'd1,
    OP_EXT  = 2'd2,
    OP_IDLE = 2'd3
  } vop_e;

  localparam int NUM_LW = 3;
endpackage

// File: rtl/vcmp_lane_cmp.sv
module vcmp_lane_cmp #(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 8
) (
  input  logic [VEC_W-1:0]   a,
  input  logic [VEC_W-1:0]   b,
  output logic [VEC_W/8-1:0] eq_m,
  output logic [VEC_W/8-1:0] lts_m,
  output logic [VEC_W/8-1:0] ltu_m
);
  localparam int LANES = VEC_W / LANE_W;
  localparam int BPL   = LANE_W / 8;

  function automatic logic f_lts(logic [LANE_W-1:0] x, logic [LANE_W-1:0] y);
    return $signed(x) < $signed(y);
  endfunction

  function automatic logic f_ltu(logic [LANE_W-1:0] x, logic [LANE_W-1:0] y);
    return x < y;
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] la, lb;
    assign la = a[l*LANE_W +: LANE_W];
    assign lb = b[l*LANE_W +: LANE_W];
    assign eq_m [l*BPL +: BPL] = {BPL{la == lb}};
    assign lts_m[l*BPL +: BPL] = {BPL{f_lts(la, lb)}};
    assign ltu_m[l*BPL +: BPL] = {BPL{f_ltu(la, lb)}};
  end
endmodule

// File: rtl/vcmp_move.sv
module vcmp_move #(
  parameter int VEC_W  = 128,
  parameter int SCAL_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic [VEC_W-1:0]  a,
  input  logic [SCAL_W-1:0] scalar,
  input  logic [IDX_W-1:0]  idx,
  input  logic [1:0]        width,
  output logic [VEC_W-1:0]  ins_vec,
  output logic [SCAL_W-1:0] ext_scalar
);
  import vcmp_pkg::*;

  logic [VEC_W-1:0]  ins_w [NUM_LW];
  logic [SCAL_W-1:0] ext_w [NUM_LW];

  for (genvar k = 0; k < NUM_LW; k++) begin : g_w
    localparam int LW = 8 << k;
    always_comb begin
      ins_w[k] = a;
      ins_w[k][idx*LW +: LW] = scalar[LW-1:0];
    end
    assign ext_w[k] = SCAL_W'(a[idx*LW +: LW]);
  end

  always_comb begin
    ins_vec    = '0;
    ext_scalar = '0;
    if (width != LW_BAD) begin
      ins_vec    = ins_w[width];
      ext_scalar = ext_w[width];
    end
  end
endmodule

// File: rtl/vcmp_pred_unit.sv
module vcmp_pred_unit #(
  parameter int VEC_W  = 128,
  parameter int SCAL_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           in_op,
  input  logic [1:0]           in_width,
  input  logic [VEC_W-1:0]     in_a,
  input  logic [VEC_W-1:0]     in_b,
  input  logic [SCAL_W-1:0]    in_scalar,
  input  logic [IDX_W-1:0]     in_lane,
  output logic                 out_valid,
  output logic [VEC_W/8-1:0]   out_eq,
  output logic [VEC_W/8-1:0]   out_lts,
  output logic [VEC_W/8-1:0]   out_ltu,
  output logic [VEC_W-1:0]     out_vec,
  output logic [SCAL_W-1:0]    out_scalar,
  output logic                 out_err
);
  import vcmp_pkg::*;
  localparam int NB = VEC_W / 8;

  logic [NB-1:0] eq_w [NUM_LW];
  logic [NB-1:0] lts_w[NUM_LW];
  logic [NB-1:0] ltu_w[NUM_LW];

  for (genvar k = 0; k < NUM_LW; k++) begin : g_cmp
    vcmp_lane_cmp #(.VEC_W(VEC_W), .LANE_W(8 << k)) u_cmp (
      .a(in_a), .b(in_b),
      .eq_m(eq_w[k]), .lts_m(lts_w[k]), .ltu_m(ltu_w[k])
    );
  end

  logic [VEC_W-1:0]  ins_vec;
  logic [SCAL_W-1:0] ext_scalar;

  vcmp_move #(.VEC_W(VEC_W), .SCAL_W(SCAL_W), .IDX_W(IDX_W)) u_move (
    .a(in_a), .scalar(in_scalar), .idx(in_lane), .width(in_width),
    .ins_vec(ins_vec), .ext_scalar(ext_scalar)
  );

  // named internal events
  logic width_ok;
  logic load_en;
  vop_e op;
  assign width_ok = (lane_w_e'(in_width) != LW_BAD);
  assign load_en  = in_valid;
  assign op       = vop_e'(in_op);

  logic [NB-1:0]     n_eq, n_lts, n_ltu;
  logic [VEC_W-1:0]  n_vec;
  logic [SCAL_W-1:0] n_scal;

  always_comb begin
    n_eq   = '0;
    n_lts  = '0;
    n_ltu  = '0;
    n_vec  = '0;
    n_scal = '0;
    if (width_ok) begin
      case (op)
        OP_CMP: begin
          n_eq  = eq_w[in_width];
          n_lts = lts_w[in_width];
          n_ltu = ltu_w[in_width];
        end
        OP_INS:  n_vec  = ins_vec;
        OP_EXT:  n_scal = ext_scalar;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_eq     <= '0;
      out_lts    <= '0;
      out_ltu    <= '0;
      out_vec    <= '0;
      out_scalar <= '0;
      out_err    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (load_en) begin
        out_eq     <= n_eq;
        out_lts    <= n_lts;
        out_ltu    <= n_ltu;
        out_vec    <= n_vec;
        out_scalar <= n_scal;
        out_err    <= !width_ok;
      end
    end
  end
endmodule

// File: rtl/vcmp_pred_chk.sv
module vcmp_pred_chk #(
  parameter int VEC_W  = 128,
  parameter int SCAL_W = 32,
  parameter int IDX_W  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [1:0]         in_op,
  input logic [1:0]         in_width,
  input logic               out_valid,
  input logic [VEC_W/8-1:0] out_eq,
  input logic [VEC_W/8-1:0] out_lts,
  input logic [VEC_W/8-1:0] out_ltu,
  input logic [VEC_W-1:0]   out_vec,
  input logic [SCAL_W-1:0]  out_scalar,
  input logic               out_err
);
  localparam int NB = VEC_W / 8;

  function automatic logic pairs_ok(logic [NB-1:0] m);
    logic ok = 1'b1;
    for (int i = 0; i < NB; i += 2) if (m[i] != m[i+1]) ok = 1'b0;
    return ok;
  endfunction

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_pairs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'd0 && in_width == 2'd1) |=>
      (pairs_ok(out_eq) && pairs_ok(out_lts) && pairs_ok(out_ltu)));
  p_eq_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_eq & out_lts) == '0);
  p_eq_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_eq & out_ltu) == '0);
  p_bad_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_width == 2'd3) |=>
      (out_err && out_eq == '0 && out_lts == '0 && out_ltu == '0 &&
       out_vec == '0 && out_scalar == '0));
  p_ins_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'd1) |=>
      (out_eq == '0 && out_lts == '0 && out_ltu == '0 && out_scalar == '0));
  p_ext_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'd2) |=> (out_vec == '0 && out_eq == '0));
  p_cmp_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'd0) |=> (out_vec == '0 && out_scalar == '0));
  p_idle_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'd3) |=>
      (out_vec == '0 && out_scalar == '0 && out_eq == '0 && out_ltu == '0));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_eq) && $stable(out_lts) && $stable(out_ltu) &&
                   $stable(out_vec) && $stable(out_scalar) && $stable(out_err)));
endmodule

bind vcmp_pred_unit vcmp_pred_chk #(.VEC_W(VEC_W), .SCAL_W(SCAL_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_width(in_width),
  .out_valid(out_valid), .out_eq(out_eq), .out_lts(out_lts), .out_ltu(out_ltu),
  .out_vec(out_vec), .out_scalar(out_scalar), .out_err(out_err)
);

// File: tb/vcmp_pred_unit_bench.sv
`timescale 1ns/1ps
module vcmp_pred_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   in_op = '0, in_width = '0, in_lane = '0;
  logic [127:0] in_a = '0, in_b = '0;
  logic [31:0]  in_scalar = '0;
  logic         out_valid, out_err;
  logic [15:0]  out_eq, out_lts, out_ltu;
  logic [127:0] out_vec;
  logic [31:0]  out_scalar;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vcmp_pred_unit u_vcmp_pred_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_width(in_width),
    .in_a(in_a), .in_b(in_b), .in_scalar(in_scalar), .in_lane(in_lane),
    .out_valid(out_valid), .out_eq(out_eq), .out_lts(out_lts), .out_ltu(out_ltu),
    .out_vec(out_vec), .out_scalar(out_scalar), .out_err(out_err)
  );

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference model written from the requirements
  task automatic model(input int op, input int w, input logic [127:0] a, b,
                       input logic [31:0] s, input int idx,
                       output logic [15:0] eq, lts, ltu,
                       output logic [127:0] v, output logic [31:0] so, output logic err);
    int nb, lw, lane;
    logic [31:0] lm, sg, av, bv;
    eq = '0; lts = '0; ltu = '0; v = '0; so = '0;
    err = (w == 3);
    if (w < 3) begin
      nb = 1 << w;
      lw = 8 * nb;
      lm = (lw == 32) ? 32'hFFFF_FFFF : ((32'd1 << lw) - 32'd1);
      sg = 32'd1 << (lw - 1);
      if (op == 0) begin
        for (int i = 0; i < 16; i++) begin
          lane = i / nb;
          av = 32'(a >> (lane * lw)) & lm;
          bv = 32'(b >> (lane * lw)) & lm;
          eq[i]  = (av == bv);
          ltu[i] = (av < bv);
          lts[i] = ((av ^ sg) < (bv ^ sg));
        end
      end else if (op == 1) begin
        v = (a & ~({96'd0, lm} << (idx * lw))) | ({96'd0, s & lm} << (idx * lw));
      end else if (op == 2) begin
        so = 32'(a >> (idx * lw)) & lm;
      end
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic run_one(int op, int w, int idx, logic [127:0] a, b, logic [31:0] s);
    logic [15:0]  eq, lts, ltu;
    logic [127:0] v;
    logic [31:0]  so;
    logic         err;
    string mt_eq, mt_lt_s, mt_lt_u, vt, st;
    model(op, w, a, b, s, idx, eq, lts, ltu, v, so, err);
    @(negedge clk);
    in_valid = 1'b1; in_op = 2'(op); in_width = 2'(w); in_lane = 2'(idx);
    in_a = a; in_b = b; in_scalar = s;
    @(negedge clk);
    in_valid = 1'b0;
    mt_eq   = (w == 3) ? "R6" : (op == 3) ? "R10" : (w == 0) ? "R2" : "R5";
    mt_lt_s = (w == 3) ? "R6" : (op == 3) ? "R10" : (w == 0) ? "R3" : "R5";
    mt_lt_u = (w == 3) ? "R6" : (op == 3) ? "R10" : (w == 0) ? "R4" : "R5";
    vt = (op == 1) ? "R7" : (op == 0) ? "R9" : (op == 3) ? "R10" : "R8";
    st = (op == 2) ? "R8" : (op == 0) ? "R9" : (op == 3) ? "R10" : "R7";
    chk("R1 out_valid", 128'(out_valid), 128'd1);
    chk({mt_eq, " out_eq"}, 128'(out_eq), 128'(eq));
    chk({mt_lt_s, " out_lts"}, 128'(out_lts), 128'(lts));
    chk({mt_lt_u, " out_ltu"}, 128'(out_ltu), 128'(ltu));
    chk({vt, " out_vec"}, out_vec, v);
    chk({st, " out_scalar"}, 128'(out_scalar), 128'(so));
    chk("R6 out_err", 128'(out_err), 128'(err));
    // idle cycle with changed inputs: results must hold (R11)
    in_a = rnd128(); in_b = rnd128(); in_scalar = $urandom;
    in_op = 2'($urandom); in_width = 2'($urandom);
    @(negedge clk);
    chk("R1 out_valid low", 128'(out_valid), 128'd0);
    chk("R11 hold eq", 128'(out_eq), 128'(eq));
    chk("R11 hold vec", out_vec, v);
    chk("R11 hold scalar/err", {95'd0, out_err, out_scalar}, {95'd0, err, so});
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [127:0] a, b;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 reset valid/err", {126'd0, out_valid, out_err}, 128'd0);
    chk("R12 reset masks", {80'd0, out_eq, out_lts, out_ltu}, 128'd0);
    chk("R12 reset data", out_vec | 128'(out_scalar), 128'd0);
    rst_n = 1'b1;
    for (int w = 0; w < 4; w++)
      for (int op = 0; op < 4; op++)
        for (int idx = 0; idx < 4; idx++)
          for (int p = 0; p < 20; p++) begin
            a = rnd128();
            case (p % 4)
              0: b = rnd128();
              1: b = a;
              2: b = a ^ (rnd128() & rnd128() & rnd128());
              default: b = a ^ 128'h8080_8080_8080_8080_8080_8080_8080_8080;
            endcase
            run_one(op, w, idx, a, b, $urandom);
          end
    // directed boundaries: extreme signed values per lane width
    for (int w = 0; w < 3; w++) begin
      run_one(0, w, 0, {16{8'h80}}, {16{8'h7F}}, 32'd0);
      run_one(0, w, 0, {16{8'hFF}}, 128'd0, 32'd0);
      run_one(1, w, 3, {16{8'hA5}}, 128'd0, 32'hFFFF_FFFF);
      run_one(2, w, 3, {16{8'hFF}}, 128'd0, 32'd0);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule